// File: doc/BRIEF.md
# Host Configuration and PC Reset Controller

This block sits behind the host's register port of a PC emulation card. It keeps an eight-bit configuration register that the host writes to switch the emulated serial, parallel, keyboard, monochrome and colour display interfaces on or off. The same register selects one of three memory windows and carries an active-low clock-stop control. The active window is decoded into a base and a last address. How the window is placed depends on a PC/AT mode strap.

The block also drives the reset line of the emulated PC. The line is asserted while the block is in reset. A host read of a dedicated strobe offset releases it. A host write of a low bit 2 to the control offset asserts it again.

Each register offset lives in a 17-bit bank. The block decodes it in the byte-access bank (top address bits 00) and in the I/O bank (top bits 11), and ignores the other two banks. When the configuration register is read back, its top bit shows the mode strap and not the written clock-stop bit.

Top module: `hostcfg_pcrst`

## Requirements
- R1: While `rst_n` is low, and after it until the first relevant access, `pc_reset` is 1, the five interface enables are 0, `vid_kbd_clk_run` is 0 and `win_en` is 0.
- R2: A write to offset 1FFF7 or 7FFF7 stores `wdata` in the configuration register, and the outputs show it on the next cycle. Bits 0..4 drive `ser_en`, `par_en`, `kbd_en`, `mono_en` and `color_en`. The same offset in bank 01 or 10 (3FFF7, 5FFF7) has no effect.
- R3: When `rd_en` is high and `rd_addr` is the configuration offset in bank 00 or 11, `rdata` returns stored bits 6..0 with `pc_mode_strap` (1 = PC, 0 = AT) in bit 7, in the same cycle. Any other read returns 0.
- R4: `vid_kbd_clk_run` equals the last written bit 7 of the configuration register (1 = clock running).
- R5: In PC mode (strap 1), field {bit6,bit5} selects the window: 01 gives A0000..AFFFF, 10 gives D0000..DFFFF, 11 gives E0000..EFFFF, and 00 gives no window (`win_en` 0, base and last 0).
- R6: In AT mode (strap 0), the field selects the window: 01 gives A0000..AFFFF, 10 gives D4000..DFFFF, and 11 or 00 give no window.
- R7: A host read of offset 1FFF5 or 7FFF5 clears `pc_reset` on the next cycle. A read of 3FFF5 or 5FFF5, or a write to 1FFF5, leaves it unchanged.
- R8: A write to offset 1FFFD or 7FFFD with `wdata[2]` = 0 sets `pc_reset` on the next cycle. With `wdata[2]` = 1 the write leaves `pc_reset` unchanged.
- R9: When a reset assert (R8) and a release read (R7) happen in the same cycle, `pc_reset` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_mode_strap | input | 1 | 1 = PC mode, 0 = AT mode |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 19 | Host read offset |
| rdata | output | 8 | Read data, combinational |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 19 | Host write offset |
| wdata | input | 8 | Write data |
| ser_en | output | 1 | Serial emulation enable |
| par_en | output | 1 | Parallel emulation enable |
| kbd_en | output | 1 | Keyboard emulation enable |
| mono_en | output | 1 | Monochrome display enable |
| color_en | output | 1 | Colour display enable |
| vid_kbd_clk_run | output | 1 | Retrace/keyboard clock running |
| pc_reset | output | 1 | PC reset, active high |
| win_en | output | 1 | A memory window is selected |
| win_base | output | 20 | First address of the window |
| win_last | output | 20 | Last address of the window |

## Verification
A wrong bit in the configuration register shows up one cycle after the write. It appears on an enable output, on the clock-run output, or in the window base and last values. It can also be read back in the same cycle through `rdata`. A reset flop that takes a wrong value shows on `pc_reset` one edge after the strobe that should have set or cleared it. Bank decoding faults show when an access to a non-mirrored bank changes an output one cycle later.

// File: rtl/hostcfg_pcrst.sv
module hostcfg_pcrst #(
  parameter int ADDR_W = 19,
  parameter int BANK_W = 17,
  parameter int WIN_W  = 20,
  parameter logic [BANK_W-1:0] OFS_RST_REL = 17'h1FFF5,
  parameter logic [BANK_W-1:0] OFS_CFG     = 17'h1FFF7,
  parameter logic [BANK_W-1:0] OFS_CTRL    = 17'h1FFFD,
  parameter int CTRL_RST_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_mode_strap,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rdata,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wdata,
  output logic              ser_en,
  output logic              par_en,
  output logic              kbd_en,
  output logic              mono_en,
  output logic              color_en,
  output logic              vid_kbd_clk_run,
  output logic              pc_reset,
  output logic              win_en,
  output logic [WIN_W-1:0]  win_base,
  output logic [WIN_W-1:0]  win_last
);
  localparam int SEL_W = ADDR_W - BANK_W;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [BANK_W-1:0] ofs);
    logic [SEL_W-1:0] bank;
    bank = a[ADDR_W-1:BANK_W];
    return (a[BANK_W-1:0] == ofs) && ((bank == '0) || (bank == '1));
  endfunction

  logic [7:0] cfg_q;
  logic       rst_q;

  wire cfg_wr   = wr_en && hit(wr_addr, OFS_CFG);
  wire rst_set  = wr_en && hit(wr_addr, OFS_CTRL) && !wdata[CTRL_RST_BIT];
  wire rst_clr  = rd_en && hit(rd_addr, OFS_RST_REL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rst_q <= 1'b1;
    end else begin
      if (cfg_wr) cfg_q <= wdata;
      if (rst_set)      rst_q <= 1'b1;
      else if (rst_clr) rst_q <= 1'b0;
    end
  end

  assign {ser_en, par_en, kbd_en, mono_en, color_en} =
         {cfg_q[0], cfg_q[1], cfg_q[2], cfg_q[3], cfg_q[4]};
  assign vid_kbd_clk_run = cfg_q[7];
  assign pc_reset        = rst_q;
  assign rdata = (rd_en && hit(rd_addr, OFS_CFG)) ? {pc_mode_strap, cfg_q[6:0]} : 8'h00;

  always_comb begin
    win_en   = 1'b0;
    win_base = '0;
    win_last = '0;
    unique case (cfg_q[6:5])
      2'b01: begin
        win_en = 1'b1; win_base = WIN_W'('hA0000); win_last = WIN_W'('hAFFFF);
      end
      2'b10: begin
        win_en   = 1'b1;
        win_base = pc_mode_strap ? WIN_W'('hD0000) : WIN_W'('hD4000);
        win_last = WIN_W'('hDFFFF);
      end
      2'b11: if (pc_mode_strap) begin
        win_en = 1'b1; win_base = WIN_W'('hE0000); win_last = WIN_W'('hEFFFF);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hostcfg_pcrst_chk.sv
module hostcfg_pcrst_chk #(
  parameter int ADDR_W = 19,
  parameter int BANK_W = 17,
  parameter int WIN_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pc_mode_strap,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rdata,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wdata,
  input logic              ser_en,
  input logic              vid_kbd_clk_run,
  input logic              pc_reset,
  input logic              win_en,
  input logic [WIN_W-1:0]  win_base,
  input logic [WIN_W-1:0]  win_last
);
  localparam int SEL_W = ADDR_W - BANK_W;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [BANK_W-1:0] ofs);
    return (a[BANK_W-1:0] == ofs) &&
           ((a[ADDR_W-1:BANK_W] == '0) || (a[ADDR_W-1:BANK_W] == {SEL_W{1'b1}}));
  endfunction

  wire do_rel = rd_en && at(rd_addr, 17'h1FFF5);
  wire do_set = wr_en && at(wr_addr, 17'h1FFFD) && !wdata[2];
  wire do_cfg = wr_en && at(wr_addr, 17'h1FFF7);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rel && !do_set) |=> !pc_reset);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    do_set |=> pc_reset);
  assert_reset_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_rel && !do_set) |=> $stable(pc_reset));
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !do_cfg |=> ($stable(ser_en) && $stable(vid_kbd_clk_run)));
  assert_cfg_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_cfg |=> (vid_kbd_clk_run == $past(wdata[7])));
  assert_strap_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && at(rd_addr, 17'h1FFF7)) |-> (rdata[7] == pc_mode_strap));
  assert_window_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_en |-> (win_base < win_last));
  assert_no_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> (win_base == '0 && win_last == '0));
endmodule

bind hostcfg_pcrst hostcfg_pcrst_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .WIN_W(WIN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pc_mode_strap(pc_mode_strap),
  .rd_en(rd_en), .rd_addr(rd_addr), .rdata(rdata),
  .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
  .ser_en(ser_en), .vid_kbd_clk_run(vid_kbd_clk_run), .pc_reset(pc_reset),
  .win_en(win_en), .win_base(win_base), .win_last(win_last));

// File: tb/hostcfg_pcrst_tb_top.sv
`timescale 1ns/1ps
module hostcfg_pcrst_tb_top;
  logic clk = 0, rst_n = 0, strap = 1;
  logic rd_en = 0, wr_en = 0;
  logic [18:0] rd_addr = '0, wr_addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic ser_en, par_en, kbd_en, mono_en, color_en, clk_run, pc_reset, win_en;
  logic [19:0] win_base, win_last;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  hostcfg_pcrst dut_i (
    .clk(clk), .rst_n(rst_n), .pc_mode_strap(strap),
    .rd_en(rd_en), .rd_addr(rd_addr), .rdata(rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
    .ser_en(ser_en), .par_en(par_en), .kbd_en(kbd_en), .mono_en(mono_en),
    .color_en(color_en), .vid_kbd_clk_run(clk_run), .pc_reset(pc_reset),
    .win_en(win_en), .win_base(win_base), .win_last(win_last));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [18:0] a);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  function automatic logic [4:0] en_bits(input logic [7:0] d);
    return {d[0], d[1], d[2], d[3], d[4]};
  endfunction

  task automatic t_reset();
    chk("R1 pc_reset", pc_reset, 1);
    chk("R1 enables", {ser_en, par_en, kbd_en, mono_en, color_en}, 0);
    chk("R1 clk_run/win_en", {clk_run, win_en}, 0);
  endtask

  task automatic t_mode_write();
    wr(19'h1FFF7, 8'h15);
    chk("R2 bank00 write", {ser_en, par_en, kbd_en, mono_en, color_en}, en_bits(8'h15));
    wr(19'h7FFF7, 8'h8A);
    chk("R2 bank11 write", {ser_en, par_en, kbd_en, mono_en, color_en}, en_bits(8'h8A));
    chk("R4 clk_run high", clk_run, 1);
    wr(19'h3FFF7, 8'h1F);
    chk("R2 bank01 ignored", {ser_en, par_en, kbd_en, mono_en, color_en}, en_bits(8'h8A));
    wr(19'h5FFF7, 8'h00);
    chk("R4 bank10 ignored", clk_run, 1);
    wr(19'h1FFF7, 8'h0A);
    chk("R4 clk_run low", clk_run, 0);
  endtask

  task automatic t_readback();
    wr(19'h1FFF7, 8'h35);
    @(negedge clk); rd_en = 1; rd_addr = 19'h1FFF7; strap = 1; #1;
    chk("R3 read PC strap", rdata, 8'hB5);
    strap = 0; #1;
    chk("R3 read AT strap", rdata, 8'h35);
    rd_addr = 19'h7FFF7; #1;
    chk("R3 mirror read", rdata, 8'h35);
    rd_addr = 19'h3FFF7; #1;
    chk("R3 other bank reads 0", rdata, 8'h00);
    @(negedge clk); rd_en = 0; strap = 1; #1;
    chk("R3 idle reads 0", rdata, 8'h00);
    wr(19'h1FFF7, 8'hFF);
    @(negedge clk); rd_en = 1; rd_addr = 19'h1FFF7; strap = 0; #1;
    chk("R3 bit7 is strap not clk stop", rdata, 8'h7F);
    @(negedge clk); rd_en = 0; strap = 1;
  endtask

  task automatic t_window(input logic mode);
    for (int s = 0; s < 4; s++) begin
      logic e; logic [19:0] b, l;
      e = 0; b = 0; l = 0;
      case (s)
        1: begin e = 1; b = 20'hA0000; l = 20'hAFFFF; end
        2: begin e = 1; b = mode ? 20'hD0000 : 20'hD4000; l = 20'hDFFFF; end
        3: if (mode) begin e = 1; b = 20'hE0000; l = 20'hEFFFF; end
        default: ;
      endcase
      wr(19'h1FFF7, {1'b0, s[1:0], 5'h00});
      strap = mode; #1;
      if (mode) chk("R5 PC window", {win_en, win_base, win_last}, {e, b, l});
      else      chk("R6 AT window", {win_en, win_base, win_last}, {e, b, l});
    end
    strap = 1;
  endtask

  task automatic t_reset_line();
    rd(19'h3FFF5);
    chk("R7 bank01 read no release", pc_reset, 1);
    rd(19'h5FFF5);
    chk("R7 bank10 read no release", pc_reset, 1);
    wr(19'h1FFF5, 8'h00);
    chk("R7 write no release", pc_reset, 1);
    rd(19'h1FFF5);
    chk("R7 release via 1FFF5", pc_reset, 0);
    wr(19'h1FFFD, 8'hFF);
    chk("R8 bit2 high no effect", pc_reset, 0);
    wr(19'h3FFFD, 8'h00);
    chk("R8 bank01 ctrl ignored", pc_reset, 0);
    wr(19'h7FFFD, 8'hFB);
    chk("R8 assert via 7FFFD", pc_reset, 1);
    rd(19'h7FFF5);
    chk("R7 release via 7FFF5", pc_reset, 0);
    wr(19'h1FFFD, 8'h00);
    chk("R8 assert via 1FFFD", pc_reset, 1);
  endtask

  task automatic t_conflict();
    rd(19'h1FFF5);
    chk("R9 released before", pc_reset, 0);
    @(negedge clk);
    rd_en = 1; rd_addr = 19'h1FFF5; wr_en = 1; wr_addr = 19'h1FFFD; wdata = 8'hFB;
    @(negedge clk); rd_en = 0; wr_en = 0;
    chk("R9 assert wins", pc_reset, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mode_write();
    t_readback();
    t_window(1'b1);
    t_window(1'b0);
    t_reset_line();
    t_conflict();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule